// File: doc/BRIEF.md
# Programmable-Timing SRAM Bus Cycle Controller

This block converts a single internal read or write request into one bus cycle on an external asynchronous SRAM for a single address area. The area is recognised from the top three address bits. A request that falls in the area runs a bus cycle with a chip select, a read strobe that also acts as the SRAM output enable, and one write strobe per byte lane. A request outside the area is refused at once with an error flag and causes no bus activity.

The cycle is shaped by configuration inputs that are captured when the request is accepted. A setup bit puts one cycle of address and chip select ahead of the strobe. A 3-bit wait code selects the number of extra strobe cycles from a fixed table. A 2-bit hold field keeps address and chip select for 0 to 3 cycles after the strobe. An external wait input stretches the strobe phase for as long as it stays high. A 2-bit size field picks an 8, 16, 32 or 64-bit data bus. The size limits which byte lanes are strobed on writes and which lanes are returned on reads.

The state machine has four states: IDLE, SETUP, STROBE and HOLD. Its transitions are:
- IDLE→SETUP on an accepted in-area request with setup 1.
- IDLE→STROBE on an accepted in-area request with setup 0.
- SETUP→STROBE after one cycle.
- STROBE→STROBE while wait cycles remain, or while the external wait input is high on the last programmed cycle.
- STROBE→HOLD when the strobe ends and hold is non-zero.
- STROBE→IDLE when the strobe ends and hold is zero.
- HOLD→HOLD while hold cycles remain.
- HOLD→IDLE when the last hold cycle ends.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A request is in the area when address bits [28:26] equal 3'b100. Such a request runs one bus cycle, and the chip select (active low) is asserted for every cycle of its setup, strobe and hold phases and for no other cycle.
- R2: A request outside the area is answered by ready together with an error flag, combinationally, in the cycle it is first seen. The chip select and all strobes stay inactive for it.
- R3: With the setup bit at 1, exactly one cycle of chip select without a strobe comes before the strobe. With the setup bit at 0 there is none.
- R4: With no external wait, the strobe lasts 1 + N cycles, where N comes from the wait code: codes 0..7 give N = 0, 1, 2, 3, 6, 9, 12, 15.
- R5: The external wait input (active high) is sampled on the last programmed strobe cycle and on each later one. While it is high the strobe is held, so each high sample adds one strobe cycle.
- R6: After the strobe, the chip select stays asserted without a strobe for exactly the number of cycles given by the 2-bit hold field (0 to 3).
- R7: On a read, the read/output-enable strobe (active low) is the only strobe. The data captured is the bus value in the final strobe cycle. The write strobes and the read strobe are never active together.
- R8: On a write, write strobe i (active low) is asserted only when byte enable i is set and lane i lies within the bus width. The write data is driven and stays stable while the strobes are active.
- R9: Size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 byte lanes. Read data lanes beyond the width return zero.
- R10: For an in-area access, ready (without error) is high for exactly one cycle, in the first cycle after chip select is released.
- R11: After reset the chip select and all strobes are inactive and ready and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Request byte address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables |
| req_ready | output | 1 | Request completed |
| req_err | output | 1 | Request refused (outside area), with ready |
| req_rdata | output | 64 | Read data, valid with ready |
| cfg_setup | input | 1 | Setup cycle enable |
| cfg_wait | input | 3 | Wait code |
| cfg_hold | input | 2 | Hold cycles |
| cfg_size | input | 2 | Bus width code |
| sram_cs_n | output | 1 | Area chip select, active low |
| sram_oe_n | output | 1 | Read strobe / output enable, active low |
| sram_we_n | output | 8 | Per-lane write strobes, active low |
| sram_addr | output | 29 | Address to the SRAM |
| sram_dq_out | output | 64 | Write data to the bus |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 64 | Data from the bus |
| sram_wait | input | 1 | External wait, active high |

## Verification
The bench builds the block with its default parameters: a 29-bit address, a 64-bit data bus and area code 3'b100. These defaults make all four size codes and all eight byte lanes reachable. They also let both a code just below the area (3'b011) and one just above it (3'b101) be driven as refused requests. Every wait code, every hold value and both setup values are applied. The bench's bus model changes the read data on every strobe cycle, which pins down the capture cycle, and it raises the wait input for a chosen number of cycles.

// File: rtl/sram_cycle_pkg.sv
package sram_cycle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } cyc_state_t;

    // Wait code to extra strobe cycles: 0..3 direct, then steps of three.
    function automatic logic [3:0] wait_cycles(input logic [2:0] code);
        logic [3:0] c;
        c = {1'b0, code};
        if (code < 3'd4)
            return c;
        return (c - 4'd2) * 4'd3;
    endfunction

endpackage

// File: rtl/sram_area_decode.sv
module sram_area_decode #(
    parameter int                ADDR_W    = 29,
    parameter int                AREA_W    = 3,
    parameter logic [AREA_W-1:0] AREA_CODE = 3'b100
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    assign hit = (addr[ADDR_W-1 -: AREA_W] == AREA_CODE);
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES  = 8,
    parameter int SIZE_W = 2
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [LANES-1:0]  be,
    output logic [LANES-1:0]  lane_en,
    output logic [LANES-1:0]  be_eff
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = (i < (32'd1 << size));
        assign be_eff[i]  = lane_en[i] & be[i];
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_cycle_pkg::*;
#(
    parameter int                ADDR_W    = 29,
    parameter int                DATA_W    = 64,
    parameter int                AREA_W    = 3,
    parameter logic [AREA_W-1:0] AREA_CODE = 3'b100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  req_ready,
    output logic                  req_err,
    output logic [DATA_W-1:0]     req_rdata,
    input  logic                  cfg_setup,
    input  logic [2:0]            cfg_wait,
    input  logic [1:0]            cfg_hold,
    input  logic [1:0]            cfg_size,
    output logic                  sram_cs_n,
    output logic                  sram_oe_n,
    output logic [DATA_W/8-1:0]   sram_we_n,
    output logic [ADDR_W-1:0]     sram_addr,
    output logic [DATA_W-1:0]     sram_dq_out,
    output logic                  sram_dq_oe,
    input  logic [DATA_W-1:0]     sram_dq_in,
    input  logic                  sram_wait
);
    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = 4;

    cyc_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, wait_q;
    logic [1:0]        hold_q;
    logic              write_q, ready_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, cap_data;
    logic [LANES-1:0]  we_mask_q, lane_q;
    logic              hit, start, miss_ack, leave_strobe, finish;
    logic [LANES-1:0]  lane_en, be_eff;

    sram_area_decode #(
        .ADDR_W(ADDR_W), .AREA_W(AREA_W), .AREA_CODE(AREA_CODE)
    ) u_decode (
        .addr(req_addr), .hit(hit)
    );

    sram_lane_mask #(
        .LANES(LANES), .SIZE_W(2)
    ) u_lanes (
        .size(cfg_size), .be(req_be), .lane_en(lane_en), .be_eff(be_eff)
    );

    assign start        = (state_q == ST_IDLE) && req_valid && !ready_q && hit;
    assign miss_ack     = (state_q == ST_IDLE) && req_valid && !ready_q && !hit;
    assign leave_strobe = (state_q == ST_STROBE) && (cnt_q == '0) && !sram_wait;
    assign finish       = (leave_strobe && (hold_q == 2'd0)) ||
                          ((state_q == ST_HOLD) && (cnt_q == '0));

    for (genvar i = 0; i < LANES; i++) begin : g_cap
        assign cap_data[i*8 +: 8] = lane_q[i] ? sram_dq_in[i*8 +: 8] : 8'h00;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = cfg_setup ? ST_SETUP : ST_STROBE;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (leave_strobe) state_d = (hold_q != 2'd0) ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (cnt_q == '0) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Counters, captured request and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            wait_q    <= '0;
            hold_q    <= '0;
            write_q   <= 1'b0;
            ready_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            we_mask_q <= '0;
            lane_q    <= '0;
        end else begin
            ready_q <= finish;
            if (start) begin
                wait_q    <= wait_cycles(cfg_wait);
                hold_q    <= cfg_hold;
                write_q   <= req_write;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                we_mask_q <= be_eff;
                lane_q    <= lane_en;
                cnt_q     <= wait_cycles(cfg_wait);
            end else if (state_q == ST_SETUP) begin
                cnt_q <= wait_q;
            end else if (state_q == ST_STROBE) begin
                if (cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
                else if (leave_strobe)
                    cnt_q <= {2'b00, hold_q} - 1'b1;
            end else if (state_q == ST_HOLD && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (leave_strobe && !write_q)
                rdata_q <= cap_data;
        end
    end

    // Outputs
    always_comb begin
        sram_cs_n   = (state_q == ST_IDLE);
        sram_oe_n   = !((state_q == ST_STROBE) && !write_q);
        sram_we_n   = ((state_q == ST_STROBE) && write_q) ? ~we_mask_q : '1;
        sram_dq_oe  = write_q && (state_q != ST_IDLE);
        sram_dq_out = wdata_q;
        sram_addr   = addr_q;
        req_ready   = ready_q | miss_ack;
        req_err     = miss_ack;
        req_rdata   = rdata_q;
    end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
    parameter int                ADDR_W    = 29,
    parameter int                DATA_W    = 64,
    parameter int                AREA_W    = 3,
    parameter logic [AREA_W-1:0] AREA_CODE = 3'b100
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                req_err,
    input logic                sram_cs_n,
    input logic                sram_oe_n,
    input logic [DATA_W/8-1:0] sram_we_n,
    input logic [ADDR_W-1:0]   sram_addr,
    input logic [DATA_W-1:0]   sram_dq_out,
    input logic                sram_wait
);
    p_strobe_in_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n || sram_we_n != '1) |-> !sram_cs_n);

    p_area_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n) |-> (sram_addr[ADDR_W-1 -: AREA_W] == AREA_CODE));

    p_err_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && sram_cs_n));

    p_wait_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && sram_wait) |=> !sram_oe_n);

    p_wait_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we_n != '1 && sram_wait) |=> $stable(sram_we_n));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && sram_we_n != '1));

    p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we_n != '1) |=> (sram_we_n == '1 || $stable(sram_dq_out)));

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_err) |=> !(req_ready && !req_err));
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AREA_W(AREA_W), .AREA_CODE(AREA_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
    .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_wait(sram_wait)
);

// File: tb/sram_cycle_ctrl_tb_top.sv
module sram_cycle_ctrl_tb_top;
    typedef struct {
        bit          is_err;
        bit          write;
        int          setup;
        int          strobes;
        int          hold;
        int          ext;
        int          nwait;
        logic [7:0]  we_lanes;
        logic [63:0] data;
        logic [63:0] base;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [28:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        req_ready, req_err;
    logic [63:0] req_rdata;
    logic        cfg_setup = 1'b0;
    logic [2:0]  cfg_wait = '0;
    logic [1:0]  cfg_hold = '0, cfg_size = '0;
    logic        sram_cs_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_we_n;
    logic [28:0] sram_addr;
    logic [63:0] sram_dq_out;
    logic [63:0] sram_dq_in = '0;
    logic        sram_wait = 1'b0;

    int   n_checks = 0, n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    sram_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .req_err(req_err), .req_rdata(req_rdata),
        .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .cfg_size(cfg_size), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in), .sram_wait(sram_wait)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wait_table(input logic [2:0] code);
        case (code)
            3'd0: return 0;  3'd1: return 1;  3'd2: return 2;  3'd3: return 3;
            3'd4: return 6;  3'd5: return 9;  3'd6: return 12; default: return 15;
        endcase
    endfunction

    // Driver: pushes the expected item, then holds the request until ready.
    task automatic access(input bit wr, input logic [2:0] area, input logic [7:0] be,
                          input logic [63:0] wd, input bit su, input logic [2:0] wc,
                          input logic [1:0] hd, input logic [1:0] sz, input int ext,
                          input logic [63:0] base);
        exp_t e;
        int   lanes;
        logic [63:0] m;
        lanes = 1 << sz;
        m = '0;
        for (int i = 0; i < lanes; i++) m[i*8 +: 8] = 8'hFF;
        e.is_err   = (area != 3'b100);
        e.write    = wr;
        e.setup    = su;
        e.nwait    = wait_table(wc);
        e.ext      = ext;
        e.strobes  = e.nwait + 1 + ext;
        e.hold     = hd;
        e.we_lanes = be & m[7:0] ;
        for (int i = 0; i < 8; i++) e.we_lanes[i] = be[i] && (i < lanes);
        e.data     = wr ? wd : ((base ^ 64'(e.strobes)) & m);
        e.base     = base;
        @(negedge clk);
        q.push_back(e);
        req_write = wr;
        req_addr  = {area, 26'h0A5_5A5 + 26'(n_checks)};
        req_be    = be;
        req_wdata = wd;
        cfg_setup = su;
        cfg_wait  = wc;
        cfg_hold  = hd;
        cfg_size  = sz;
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        req_valid = 1'b0;
        cfg_wait  = 3'd7;
        cfg_hold  = 2'd3;
        cfg_setup = 1'b1;
    endtask

    // Monitor and bus model: samples 2 ns after each rising edge.
    int          cs_cnt = 0, su_cnt = 0, str_cnt = 0, hd_cnt = 0;
    logic [7:0]  we_acc = '0;
    bit          oe_seen = 0, we_seen = 0;
    logic [63:0] wd_seen = '0;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (!sram_cs_n) begin
                cs_cnt++;
                if (!sram_oe_n || sram_we_n != 8'hFF) begin
                    str_cnt++;
                    we_acc |= ~sram_we_n;
                    if (!sram_oe_n) oe_seen = 1;
                    if (sram_we_n != 8'hFF) begin
                        we_seen = 1;
                        wd_seen = sram_dq_out;
                    end
                end else if (str_cnt == 0) su_cnt++;
                else hd_cnt++;
            end
            if ((!sram_oe_n || sram_we_n != 8'hFF) && q.size() > 0) begin
                sram_wait  = (str_cnt <= q[0].nwait + q[0].ext);
                sram_dq_in = q[0].base ^ 64'(str_cnt);
            end else begin
                sram_wait  = 1'b0;
            end
            if (req_ready) begin
                if (q.size() == 0) begin
                    check(0, "R10 unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(req_err == e.is_err, "R2 error flag", 64'(req_err), 64'(e.is_err));
                    if (e.is_err) begin
                        check(cs_cnt == 0, "R2 no bus cycle", 64'(cs_cnt), 0);
                    end else begin
                        check(sram_cs_n, "R10 ready after cs release", 64'(sram_cs_n), 1);
                        check(cs_cnt == e.setup + e.strobes + e.hold, "R1 cs cycles",
                              64'(cs_cnt), 64'(e.setup + e.strobes + e.hold));
                        check(su_cnt == e.setup, "R3 setup cycles", 64'(su_cnt), 64'(e.setup));
                        check(str_cnt == e.strobes, "R4 R5 strobe cycles",
                              64'(str_cnt), 64'(e.strobes));
                        check(hd_cnt == e.hold, "R6 hold cycles", 64'(hd_cnt), 64'(e.hold));
                        if (e.write) begin
                            check(!oe_seen, "R7 no read strobe on write", 64'(oe_seen), 0);
                            check(we_acc == e.we_lanes, "R8 R9 write lanes",
                                  64'(we_acc), 64'(e.we_lanes));
                            check(wd_seen == e.data, "R8 write data", wd_seen, e.data);
                        end else begin
                            check(!we_seen, "R7 no write strobe on read", 64'(we_seen), 0);
                            check(req_rdata == e.data, "R7 R9 read capture", req_rdata, e.data);
                        end
                    end
                end
                cs_cnt = 0; su_cnt = 0; str_cnt = 0; hd_cnt = 0;
                we_acc = '0; oe_seen = 0; we_seen = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(sram_cs_n === 1'b1, "R11 cs idle", 64'(sram_cs_n), 1);
        check(sram_oe_n === 1'b1 && sram_we_n === 8'hFF, "R11 strobes idle",
              {55'd0, sram_oe_n, sram_we_n}, {55'd0, 1'b1, 8'hFF});
        check(req_ready === 1'b0 && req_err === 1'b0, "R11 ready/err low",
              {62'd0, req_ready, req_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        access(0, 3'b100, 8'hFF, '0, 0, 3'd0, 2'd0, 2'd3, 0, 64'h1122_3344_5566_7788);
        access(0, 3'b100, 8'hFF, '0, 1, 3'd7, 2'd3, 2'd2, 0, 64'hCAFE_F00D_DEAD_BEEF);
        access(1, 3'b100, 8'hA5, 64'h0102_0304_0506_0708, 1, 3'd4, 2'd2, 2'd3, 0, '0);
        access(1, 3'b100, 8'hFF, 64'hFFEE_DDCC_BBAA_9988, 0, 3'd1, 2'd1, 2'd0, 0, '0);
        access(1, 3'b100, 8'hFE, 64'h1357_9BDF_2468_ACE0, 0, 3'd2, 2'd0, 2'd1, 0, '0);
        access(0, 3'b100, 8'hFF, '0, 0, 3'd2, 2'd1, 2'd3, 5, 64'hA5A5_5A5A_0F0F_F0F0);
        access(1, 3'b100, 8'h3C, 64'h0BAD_C0DE_FACE_B00C, 1, 3'd0, 2'd2, 2'd3, 3, '0);
        access(0, 3'b011, 8'hFF, '0, 1, 3'd3, 2'd3, 2'd3, 0, '0);
        access(1, 3'b101, 8'hFF, 64'h1, 0, 3'd0, 2'd0, 2'd3, 0, '0);
        access(0, 3'b100, 8'hFF, '0, 0, 3'd5, 2'd1, 2'd1, 0, 64'h7766_5544_3322_1100);
        access(0, 3'b100, 8'hFF, '0, 1, 3'd0, 2'd0, 2'd0, 1, 64'h0000_0000_0000_00C3);
        for (int c = 0; c < 8; c++)
            access(0, 3'b100, 8'hFF, '0, c[0], 3'(c), 2'(c), 2'd3, 0,
                   64'h0123_4567_89AB_CDEF + 64'(c));
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R10 all accesses completed", 64'(q.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule